// File: doc/BRIEF.md
# Authentication Failure Lockout Counter

This block sits beside an authentication-protected command interface and throttles password guessing. Every rejected authentication attempt raises a failure count. Once that count reaches a programmable ceiling, the block raises a locked flag and the command interface refuses protected commands. A recovery timer counts ticks of an external once-per-second enable strobe. Each time a full recovery interval passes without a new failure, the count drops by one. A clear command wipes the count. A parameter write can disable the lockout altogether.

Software programs the ceiling, the recovery interval and the lockout enable through a single write strobe. It reads them back together with the live count. The decay timer is a two-state machine. `ST_REST` holds while the count is zero and the timer is idle. `ST_WAIT` runs the timer while the count is non-zero. The transitions are:

- `ST_REST` to `ST_WAIT` on an accepted failure.
- `ST_WAIT` to `ST_WAIT` on a failure, which restarts the timer, or on a tick that does not complete the interval.
- `ST_WAIT` to `ST_REST` on a clear command, on a decrement from a count of one, or when the count is found to be zero.

Top module: `lockout_guard`

## Requirements
- R1: A failure strobe accepted while unlocked raises `fail_count` by one on the next clock. The count stays at the programmed ceiling instead of passing it.
- R2: `locked` is high exactly while lockout is enabled and `fail_count` is greater than or equal to the ceiling. It therefore rises in the cycle after the failure that reaches the ceiling.
- R3: After the programmed number of `tick_1hz` pulses with no accepted failure, `fail_count` falls by one. The count never drops below zero. The count never falls without a tick. A decrement that takes the count below the ceiling clears `locked` in that same cycle. An interval value of 0 behaves as 1.
- R4: An accepted failure restarts the recovery timer. If a failure arrives in the same cycle as the tick that completes the interval, the failure wins: the count rises and no decrement happens.
- R5: With the lockout enable cleared, `locked` is never high. Failures still count and still stop at the ceiling.
- R6: `clr_cmd` sets `fail_count` to zero on the next clock and restarts the timer. It takes priority over a failure in the same cycle.
- R7: `auth_pass` never changes `fail_count`.
- R8: Failure strobes that arrive while `locked` is high are ignored. They neither change the count nor restart the timer.
- R9: When `prm_we` is high, the ceiling, interval and enable load in one clock and appear on the readback ports in the next cycle. If the new ceiling is at or below the current count and lockout is enabled, `locked` rises in that cycle.
- R10: After reset, the count is 0 and `locked` is low. The ceiling reads 3, the interval reads 4 and the enable reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle recovery time-base strobe |
| auth_pass | input | 1 | Successful authentication strobe |
| auth_fail | input | 1 | Failed authentication strobe |
| clr_cmd | input | 1 | Clear the failure count |
| prm_we | input | 1 | Parameter write strobe |
| prm_max_tries | input | CNT_W | Ceiling value to write |
| prm_interval | input | IVL_W | Recovery interval to write, in ticks |
| prm_lock_en | input | 1 | Lockout enable to write |
| locked | output | 1 | Protected commands must be refused |
| fail_count | output | CNT_W | Current failure count |
| rd_max_tries | output | CNT_W | Ceiling readback |
| rd_interval | output | IVL_W | Interval readback |
| rd_lock_en | output | 1 | Enable readback |

## Verification
Two pairs of functions can fall in the same clock cycle.

The first pair is a failure strobe and the tick that completes a recovery interval. The bench lets the timer run to one tick short of the interval, then drives both in the same cycle. It judges the outcome by the count rising rather than falling. It then checks that a fresh full interval is needed before the next decrement.

The second pair is a clear command and a failure in the same cycle. This is judged by the count reading zero one clock later.

// File: rtl/lockout_pkg.sv
package lockout_pkg;
    typedef enum logic [0:0] {
        ST_REST = 1'b0,
        ST_WAIT = 1'b1
    } decay_st_t;
endpackage

// File: rtl/lk_param_bank.sv
module lk_param_bank #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned IVL_W   = 16,
    parameter int unsigned RST_MAX = 3,
    parameter int unsigned RST_IVL = 4,
    parameter bit          RST_EN  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CNT_W-1:0] max_in,
    input  logic [IVL_W-1:0] ivl_in,
    input  logic             en_in,
    output logic [CNT_W-1:0] max_q,
    output logic [IVL_W-1:0] ivl_q,
    output logic             en_q
);
    localparam logic [CNT_W-1:0] MAX_INIT = CNT_W'(RST_MAX);
    localparam logic [IVL_W-1:0] IVL_INIT = IVL_W'(RST_IVL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            max_q <= MAX_INIT;
            ivl_q <= IVL_INIT;
            en_q  <= RST_EN;
        end else if (we) begin
            max_q <= max_in;
            ivl_q <= ivl_in;
            en_q  <= en_in;
        end
    end
endmodule

// File: rtl/lk_decay_fsm.sv
module lk_decay_fsm
    import lockout_pkg::*;
#(
    parameter int unsigned IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             fail_acc,
    input  logic             clr,
    input  logic             cnt_nz,
    input  logic             cnt_one,
    input  logic [IVL_W-1:0] ivl,
    output logic             dec_now
);
    localparam int unsigned EXT_W = IVL_W + 1;

    decay_st_t        st_q, st_d;
    logic [IVL_W-1:0] tmr_q;
    logic             span_done;

    assign span_done = (EXT_W'(tmr_q) + EXT_W'(1)) >= EXT_W'(ivl);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_REST;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_REST: begin
                if (fail_acc) st_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (clr)                           st_d = ST_REST;
                else if (fail_acc)                 st_d = ST_WAIT;
                else if (!cnt_nz)                  st_d = ST_REST;
                else if (dec_now && cnt_one)       st_d = ST_REST;
                else                               st_d = ST_WAIT;
            end
            default: st_d = ST_REST;
        endcase
    end

    // outputs
    always_comb begin
        dec_now = 1'b0;
        unique case (st_q)
            ST_REST: dec_now = 1'b0;
            ST_WAIT: dec_now = tick && !fail_acc && !clr && cnt_nz && span_done;
            default: dec_now = 1'b0;
        endcase
    end

    // interval timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (clr || fail_acc || st_q == ST_REST) begin
            tmr_q <= '0;
        end else if (tick) begin
            tmr_q <= span_done ? '0 : tmr_q + 1'b1;
        end
    end
endmodule

// File: rtl/lk_fail_counter.sv
module lk_fail_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fail_acc,
    input  logic             dec_now,
    input  logic [CNT_W-1:0] max_q,
    output logic [CNT_W-1:0] count_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (fail_acc) begin
            if (count_q < max_q) count_q <= count_q + 1'b1;
        end else if (dec_now && count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end
endmodule

// File: rtl/lockout_guard.sv
module lockout_guard #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned IVL_W   = 16,
    parameter int unsigned RST_MAX = 3,
    parameter int unsigned RST_IVL = 4,
    parameter bit          RST_EN  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_1hz,
    input  logic             auth_pass,
    input  logic             auth_fail,
    input  logic             clr_cmd,
    input  logic             prm_we,
    input  logic [CNT_W-1:0] prm_max_tries,
    input  logic [IVL_W-1:0] prm_interval,
    input  logic             prm_lock_en,
    output logic             locked,
    output logic [CNT_W-1:0] fail_count,
    output logic [CNT_W-1:0] rd_max_tries,
    output logic [IVL_W-1:0] rd_interval,
    output logic             rd_lock_en
);
    logic fail_acc;
    logic dec_now;

    lk_param_bank #(
        .CNT_W(CNT_W), .IVL_W(IVL_W),
        .RST_MAX(RST_MAX), .RST_IVL(RST_IVL), .RST_EN(RST_EN)
    ) u_prm (
        .clk(clk), .rst_n(rst_n), .we(prm_we),
        .max_in(prm_max_tries), .ivl_in(prm_interval), .en_in(prm_lock_en),
        .max_q(rd_max_tries), .ivl_q(rd_interval), .en_q(rd_lock_en)
    );

    // lock flag follows the live count with no register of its own
    assign locked   = rd_lock_en && (fail_count >= rd_max_tries);
    assign fail_acc = auth_fail && !locked && !clr_cmd;

    lk_decay_fsm #(.IVL_W(IVL_W)) u_decay (
        .clk(clk), .rst_n(rst_n), .tick(tick_1hz),
        .fail_acc(fail_acc), .clr(clr_cmd),
        .cnt_nz(fail_count != '0), .cnt_one(fail_count == CNT_W'(1)),
        .ivl(rd_interval), .dec_now(dec_now)
    );

    lk_fail_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr_cmd),
        .fail_acc(fail_acc), .dec_now(dec_now),
        .max_q(rd_max_tries), .count_q(fail_count)
    );
endmodule

// File: rtl/lockout_guard_chk.sv
module lockout_guard_chk #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned IVL_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_1hz,
    input logic             auth_pass,
    input logic             auth_fail,
    input logic             clr_cmd,
    input logic             prm_we,
    input logic [CNT_W-1:0] prm_max_tries,
    input logic [IVL_W-1:0] prm_interval,
    input logic             prm_lock_en,
    input logic             locked,
    input logic [CNT_W-1:0] fail_count,
    input logic [CNT_W-1:0] rd_max_tries,
    input logic [IVL_W-1:0] rd_interval,
    input logic             rd_lock_en
);
    localparam int unsigned EW = CNT_W + 1;

    p_fail_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (auth_fail && !locked && !clr_cmd && fail_count < rd_max_tries)
        |=> (EW'(fail_count) == EW'($past(fail_count)) + EW'(1)));

    p_lock_on_reach_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (auth_fail && !locked && !clr_cmd && !prm_we && rd_lock_en &&
         (EW'(fail_count) + EW'(1) == EW'(rd_max_tries)))
        |=> locked);

    p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_cmd |=> ((fail_count == $past(fail_count)) ||
                      (EW'(fail_count) == EW'($past(fail_count)) + EW'(1)) ||
                      (EW'(fail_count) + EW'(1) == EW'($past(fail_count)))));

    p_no_tick_no_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1hz && !clr_cmd) |=> (fail_count >= $past(fail_count)));

    p_never_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_lock_en |-> !locked);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> (fail_count == '0));

    p_pass_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (auth_pass && !auth_fail && !clr_cmd && !tick_1hz) |=> $stable(fail_count));

    p_locked_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && auth_fail && !clr_cmd && !tick_1hz) |=> $stable(fail_count));

    p_param_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prm_we |=> (rd_max_tries == $past(prm_max_tries) &&
                    rd_interval == $past(prm_interval) &&
                    rd_lock_en == $past(prm_lock_en)));
endmodule

bind lockout_guard lockout_guard_chk #(.CNT_W(CNT_W), .IVL_W(IVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .auth_pass(auth_pass),
    .auth_fail(auth_fail), .clr_cmd(clr_cmd), .prm_we(prm_we),
    .prm_max_tries(prm_max_tries), .prm_interval(prm_interval),
    .prm_lock_en(prm_lock_en), .locked(locked), .fail_count(fail_count),
    .rd_max_tries(rd_max_tries), .rd_interval(rd_interval), .rd_lock_en(rd_lock_en)
);

// File: tb/sim_lockout_guard.sv
module sim_lockout_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0, auth_pass = 1'b0, auth_fail = 1'b0, clr_cmd = 1'b0;
    logic        prm_we = 1'b0;
    logic [15:0] prm_max_tries = '0;
    logic [15:0] prm_interval = '0;
    logic        prm_lock_en = 1'b0;
    logic        locked;
    logic [15:0] fail_count, rd_max_tries, rd_interval;
    logic        rd_lock_en;

    int checks = 0;
    int errors = 0;

    // {fail, pass, clr, tick, expected count, expected locked}; ceiling 3, interval 4
    localparam logic [20:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,1'b0,16'd1,1'b0},
        {1'b1,1'b0,1'b0,1'b0,16'd2,1'b0},
        {1'b0,1'b1,1'b0,1'b0,16'd2,1'b0},
        {1'b0,1'b0,1'b0,1'b1,16'd2,1'b0},
        {1'b0,1'b0,1'b0,1'b1,16'd2,1'b0},
        {1'b0,1'b0,1'b0,1'b1,16'd2,1'b0},
        {1'b0,1'b0,1'b0,1'b1,16'd1,1'b0},
        {1'b1,1'b0,1'b0,1'b0,16'd2,1'b0},
        {1'b1,1'b0,1'b0,1'b0,16'd3,1'b1},
        {1'b1,1'b0,1'b0,1'b0,16'd3,1'b1},
        {1'b0,1'b0,1'b0,1'b1,16'd3,1'b1},
        {1'b0,1'b0,1'b0,1'b1,16'd3,1'b1},
        {1'b0,1'b0,1'b0,1'b1,16'd3,1'b1},
        {1'b0,1'b0,1'b0,1'b1,16'd2,1'b0},
        {1'b1,1'b0,1'b0,1'b1,16'd3,1'b1},
        {1'b1,1'b0,1'b1,1'b0,16'd0,1'b0}
    };

    lockout_guard u0 (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .auth_pass(auth_pass),
        .auth_fail(auth_fail), .clr_cmd(clr_cmd), .prm_we(prm_we),
        .prm_max_tries(prm_max_tries), .prm_interval(prm_interval),
        .prm_lock_en(prm_lock_en), .locked(locked), .fail_count(fail_count),
        .rd_max_tries(rd_max_tries), .rd_interval(rd_interval), .rd_lock_en(rd_lock_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic f, input logic p, input logic c, input logic t);
        auth_fail = f; auth_pass = p; clr_cmd = c; tick_1hz = t;
        @(negedge clk);
        auth_fail = 1'b0; auth_pass = 1'b0; clr_cmd = 1'b0; tick_1hz = 1'b0;
    endtask

    task automatic wr(input logic [15:0] mx, input logic [15:0] iv, input logic en);
        prm_we = 1'b1; prm_max_tries = mx; prm_interval = iv; prm_lock_en = en;
        @(negedge clk);
        prm_we = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 count", 32'(fail_count), 0);
        chk("R10 locked", 32'(locked), 0);
        chk("R10 ceiling", 32'(rd_max_tries), 3);
        chk("R10 interval", 32'(rd_interval), 4);
        chk("R10 enable", 32'(rd_lock_en), 1);

        // table: R1 R2 R3 R4 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17]);
            chk($sformatf("R1 R2 R3 R4 R6 R7 R8 vec%0d count", i), 32'(fail_count), 32'(VEC[i][16:1]));
            chk($sformatf("R2 R3 R8 vec%0d locked", i), 32'(locked), 32'(VEC[i][0]));
        end

        // R4: failure collides with the tick that would finish the interval
        step(1, 0, 0, 0);
        for (int k = 0; k < 3; k++) step(0, 0, 0, 1);
        chk("R4 before race", 32'(fail_count), 1);
        step(1, 0, 0, 1);
        chk("R4 fail wins race", 32'(fail_count), 2);
        for (int k = 0; k < 3; k++) step(0, 0, 0, 1);
        chk("R4 timer restarted", 32'(fail_count), 2);
        step(0, 0, 0, 1);
        chk("R4 full interval", 32'(fail_count), 1);

        // R9: lowering ceiling to the count locks at once
        wr(16'd1, 16'd2, 1'b1);
        chk("R9 ceiling rd", 32'(rd_max_tries), 1);
        chk("R9 interval rd", 32'(rd_interval), 2);
        chk("R9 enable rd", 32'(rd_lock_en), 1);
        chk("R9 immediate lock", 32'(locked), 1);

        // R5: disabled lockout, saturation (R1)
        wr(16'd1, 16'd2, 1'b0);
        chk("R5 disabled unlock", 32'(locked), 0);
        step(1, 0, 0, 0);
        chk("R1 saturate at ceiling", 32'(fail_count), 1);
        wr(16'd5, 16'd2, 1'b0);
        for (int k = 0; k < 6; k++) step(1, 0, 0, 0);
        chk("R1 saturate at 5", 32'(fail_count), 5);
        chk("R5 never locked", 32'(locked), 0);
        step(0, 0, 0, 1);
        chk("R3 mid interval", 32'(fail_count), 5);
        step(0, 0, 0, 1);
        chk("R3 interval two", 32'(fail_count), 4);

        // R6 clear, R3 floor at zero
        step(0, 0, 1, 0);
        chk("R6 clear", 32'(fail_count), 0);
        for (int k = 0; k < 3; k++) step(0, 0, 0, 1);
        chk("R3 floor", 32'(fail_count), 0);
        chk("R5 still unlocked", 32'(locked), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule